// File: doc/BRIEF.md
# Receive Block FIFO with Threshold and Terminator Events

This block sits between a serial receiver (asynchronous or byte-synchronous) and a CPU. Each received character is written into 64 bytes of buffer, organised as two 32-byte pools. If per-character status storage is enabled, the character's status byte is written directly after it. Stored bytes stay hidden from the reader until one of two things happens:

- the pending run reaches a programmed threshold, which fires a pool-full event; or
- an end condition occurs, which fires a termination event. An end condition is either a matching terminator character or a CPU-forced flush.

At every end condition the block latches the length of the block that just closed. It also presents the low bits of that length which, for the current threshold, tell the CPU how many bytes remain to be read.

Bytes the CPU has read keep occupying buffer space until the CPU issues a release command. When a character arrives and there is not enough room for it, the character is dropped and an overflow event fires.

The receive side is a valid/ready stream whose ready is always high: the block never pushes back, and it drops characters when storage is exhausted. The read side is a valid/ready stream with these rules:

- `rd_valid` stays high while readable bytes exist.
- `rd_data` holds steady while `rd_ready` is low.
- A byte is consumed on each clock edge where both `rd_valid` and `rd_ready` are high.

Configuration inputs, commands and events are plain pins. Commands and events are single-cycle pulses.

Top module: `rx_block_fifo`

## Requirements
- R1: After reset the following are all zero: `rd_valid`, every event, `irq_flags`, `irq` and `blk_count`.
- R2: At most 64 bytes are held; bytes count as held until released. A character needing more free bytes than are left is dropped whole, and `evt_ovf` pulses in the cycle after it was offered.
- R3: `cfg_thresh` 00/01/10/11 selects 2/4/16/32 bytes. When the pending (not yet readable) byte count reaches the threshold, every pending byte becomes readable and `evt_rpf` pulses in the next cycle.
- R4: With `cfg_term_en` high, an accepted character equal to `cfg_term_char` is stored, and the end condition follows: all pending bytes become readable and `evt_tcd` pulses in the next cycle. With `cfg_term_en` low such a character is plain data.
- R5: A `cmd_rfrd` pulse forces the end condition with or without a new character. An end condition takes precedence over a threshold hit in the same cycle, so `evt_rpf` stays low.
- R6: At each end condition, `blk_count` takes the number of bytes stored since the previous end condition, including any bytes stored in that cycle. The counter then restarts from zero.
- R7: `blk_read_len` is the low 1, 2, 4 or 5 bits of `blk_count` (threshold 00, 01, 10, 11), zero-extended to 5 bits.
- R8: With `cfg_stat_en` high, each character stores two bytes: first the data, then the status byte {5'b0, ferr, perr, par}. The threshold, the count and the space check all count stored bytes.
- R9: Readable bytes leave in arrival order. `rd_valid` and `rd_data` hold while `rd_ready` is low.
- R10: A `cmd_rmc` pulse frees every byte consumed before that cycle. No space is reclaimed without it.
- R11: `irq_flags` bit 0 = pool-full, bit 1 = termination, bit 2 = overflow. A bit sets one cycle after its event pulse and is cleared by `irq_ack`, with set winning over clear. `irq` is the OR of the three bits.
- R12: `rx_ready` is constantly high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character present |
| rx_ready | output | 1 | Always high |
| rx_data | input | 8 | Received character |
| rx_par | input | 1 | Received parity bit |
| rx_perr | input | 1 | Parity error flag |
| rx_ferr | input | 1 | Framing error flag (asynchronous mode only) |
| cfg_thresh | input | 2 | Threshold select |
| cfg_term_en | input | 1 | Terminator detection enable |
| cfg_term_char | input | 8 | Terminator value |
| cfg_stat_en | input | 1 | Store a status byte per character |
| cmd_rfrd | input | 1 | Force end condition |
| cmd_rmc | input | 1 | Release consumed bytes |
| rd_valid | output | 1 | Readable byte present |
| rd_ready | input | 1 | Reader takes a byte |
| rd_data | output | 8 | Oldest readable byte |
| evt_rpf | output | 1 | Pool-full event pulse |
| evt_tcd | output | 1 | Termination event pulse |
| evt_ovf | output | 1 | Overflow event pulse |
| irq_flags | output | 3 | Sticky event bits |
| irq_ack | input | 1 | Clear sticky bits |
| irq | output | 1 | Any sticky bit set |
| blk_count | output | 16 | Length of last closed block |
| blk_read_len | output | 5 | Bytes still to read, per threshold |

## Verification
The bench builds the block with its defaults: two pools of 32 bytes and a 16-bit block counter. With those values the 32-byte threshold, a completely full buffer and the drop of the 65th byte are all reached within a few dozen cycles. A long randomised run then exercises two kinds of collision while the buffer refills:

- threshold changes and status-mode changes taking effect part-way through a block;
- forced flushes landing together with a terminator, and releases landing together with reads.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  typedef struct packed {
    logic ferr;
    logic perr;
    logic par;
  } rx_stat_t;

  localparam int IRQ_N   = 3;
  localparam int IRQ_RPF = 0;
  localparam int IRQ_TCD = 1;
  localparam int IRQ_OVF = 2;

  function automatic logic [5:0] thresh_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   thresh_bytes = 6'd2;
      2'b01:   thresh_bytes = 6'd4;
      2'b10:   thresh_bytes = 6'd16;
      default: thresh_bytes = 6'd32;
    endcase
  endfunction

  function automatic logic [4:0] len_mask(input logic [1:0] sel);
    case (sel)
      2'b00:   len_mask = 5'h01;
      2'b01:   len_mask = 5'h03;
      2'b10:   len_mask = 5'h0F;
      default: len_mask = 5'h1F;
    endcase
  endfunction

endpackage

// File: rtl/rbf_mem.sv
module rbf_mem #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          we_two,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata0,
  input  logic [7:0]    wdata1,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0]    cells [DEPTH];
  logic [AW-1:0] waddr1;

  // second lane wraps naturally because DEPTH is a power of two
  assign waddr1 = waddr + AW'(1);

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata0;
    if (we && we_two) cells[waddr1] <= wdata1;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/rbf_ctrl.sv
module rbf_ctrl
  import rbf_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int CNTW  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  rx_stat_t        rx_stat,
  input  logic [1:0]      cfg_thresh,
  input  logic            cfg_term_en,
  input  logic [7:0]      cfg_term_char,
  input  logic            cfg_stat_en,
  input  logic            cmd_rfrd,
  input  logic            cmd_rmc,
  input  logic            rd_ready,
  output logic            mem_we,
  output logic            mem_two,
  output logic [AW-1:0]   mem_waddr,
  output logic [7:0]      mem_wd0,
  output logic [7:0]      mem_wd1,
  output logic [AW-1:0]   rd_addr,
  output logic            rd_valid,
  output logic            evt_rpf,
  output logic            evt_tcd,
  output logic            evt_ovf,
  output logic [CNTW-1:0] blk_count
);

  // pointers carry one extra bit so that full and empty differ
  logic [PW-1:0]   wr_ptr, cm_ptr, rd_ptr, rel_ptr;
  logic [PW-1:0]   used, space, need, step, wr_next, pend_next, thr;
  logic [CNTW-1:0] acc, acc_sum;
  logic            accept, drop, is_term, end_c, hit, pop;

  always_comb begin
    used      = wr_ptr - rel_ptr;
    space     = PW'(DEPTH) - used;
    need      = cfg_stat_en ? PW'(2) : PW'(1);
    accept    = rx_valid && (space >= need);
    drop      = rx_valid && !accept;
    step      = accept ? need : '0;
    wr_next   = wr_ptr + step;
    acc_sum   = acc + CNTW'(step);
    is_term   = accept && cfg_term_en && (rx_data == cfg_term_char);
    end_c     = is_term || cmd_rfrd;
    pend_next = wr_next - cm_ptr;
    thr       = PW'(thresh_bytes(cfg_thresh));
    hit       = !end_c && (pend_next >= thr);
    pop       = rd_valid && rd_ready;
  end

  assign rd_valid  = (rd_ptr != cm_ptr);
  assign rd_addr   = rd_ptr[AW-1:0];
  assign mem_we    = accept;
  assign mem_two   = cfg_stat_en;
  assign mem_waddr = wr_ptr[AW-1:0];
  assign mem_wd0   = rx_data;
  assign mem_wd1   = {5'b0, rx_stat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      cm_ptr    <= '0;
      rd_ptr    <= '0;
      rel_ptr   <= '0;
      acc       <= '0;
      blk_count <= '0;
      evt_rpf   <= 1'b0;
      evt_tcd   <= 1'b0;
      evt_ovf   <= 1'b0;
    end else begin
      wr_ptr  <= wr_next;
      if (end_c || hit) cm_ptr <= wr_next;
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      if (cmd_rmc) rel_ptr <= rd_ptr;
      if (end_c) begin
        blk_count <= acc_sum;
        acc       <= '0;
      end else begin
        acc       <= acc_sum;
      end
      evt_rpf <= hit;
      evt_tcd <= end_c;
      evt_ovf <= drop;
    end
  end

  assert_space_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rel_ptr) <= PW'(DEPTH));

  assert_ovf_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |-> (wr_ptr == $past(wr_ptr)));

  assert_rd_behind_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_ptr - rd_ptr) <= (wr_ptr - rd_ptr));

  assert_end_beats_pool_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_rpf && evt_tcd));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_no_free_without_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rmc |=> ((wr_ptr - rel_ptr) >= $past(wr_ptr - rel_ptr)));

endmodule

// File: rtl/rbf_irq.sv
module rbf_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         ack,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (ack)    flags[i] <= 1'b0;
    end

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !ack) |=> flags[i]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
  end

endmodule

// File: rtl/rx_block_fifo.sv
module rx_block_fifo
  import rbf_pkg::*;
#(
  parameter  int POOL_BYTES = 32,
  parameter  int POOLS      = 2,
  parameter  int CNTW       = 16,
  localparam int DEPTH      = POOL_BYTES * POOLS,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [7:0]      rx_data,
  input  logic            rx_par,
  input  logic            rx_perr,
  input  logic            rx_ferr,
  input  logic [1:0]      cfg_thresh,
  input  logic            cfg_term_en,
  input  logic [7:0]      cfg_term_char,
  input  logic            cfg_stat_en,
  input  logic            cmd_rfrd,
  input  logic            cmd_rmc,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [7:0]      rd_data,
  output logic            evt_rpf,
  output logic            evt_tcd,
  output logic            evt_ovf,
  output logic [2:0]      irq_flags,
  input  logic            irq_ack,
  output logic            irq,
  output logic [CNTW-1:0] blk_count,
  output logic [4:0]      blk_read_len
);

  rx_stat_t      stat;
  logic          mem_we, mem_two;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic [7:0]    mem_wd0, mem_wd1;
  logic [IRQ_N-1:0] ev_vec;

  assign stat     = '{ferr: rx_ferr, perr: rx_perr, par: rx_par};
  assign rx_ready = 1'b1;

  rbf_ctrl #(.DEPTH(DEPTH), .CNTW(CNTW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_stat       (stat),
    .cfg_thresh    (cfg_thresh),
    .cfg_term_en   (cfg_term_en),
    .cfg_term_char (cfg_term_char),
    .cfg_stat_en   (cfg_stat_en),
    .cmd_rfrd      (cmd_rfrd),
    .cmd_rmc       (cmd_rmc),
    .rd_ready      (rd_ready),
    .mem_we        (mem_we),
    .mem_two       (mem_two),
    .mem_waddr     (mem_waddr),
    .mem_wd0       (mem_wd0),
    .mem_wd1       (mem_wd1),
    .rd_addr       (rd_addr),
    .rd_valid      (rd_valid),
    .evt_rpf       (evt_rpf),
    .evt_tcd       (evt_tcd),
    .evt_ovf       (evt_ovf),
    .blk_count     (blk_count)
  );

  rbf_mem #(.DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .we     (mem_we),
    .we_two (mem_two),
    .waddr  (mem_waddr),
    .wdata0 (mem_wd0),
    .wdata1 (mem_wd1),
    .raddr  (rd_addr),
    .rdata  (rd_data)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[IRQ_RPF] = evt_rpf;
    ev_vec[IRQ_TCD] = evt_tcd;
    ev_vec[IRQ_OVF] = evt_ovf;
  end

  rbf_irq #(.N(IRQ_N)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_vec),
    .ack   (irq_ack),
    .flags (irq_flags)
  );

  assign irq          = |irq_flags;
  assign blk_read_len = blk_count[4:0] & len_mask(cfg_thresh);

  assert_rd_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_data));

  assert_events_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_rpf, evt_tcd}));

endmodule

// File: tb/rx_block_fifo_bench.sv
`timescale 1ns/1ps
module rx_block_fifo_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_par = 0, rx_perr = 0, rx_ferr = 0;
  logic [7:0] rx_data = 0, cfg_term_char = 8'h0D;
  logic [1:0] cfg_thresh = 0;
  logic cfg_term_en = 0, cfg_stat_en = 0, cmd_rfrd = 0, cmd_rmc = 0;
  logic rd_ready = 0, irq_ack = 0;
  logic rx_ready, rd_valid, evt_rpf, evt_tcd, evt_ovf, irq;
  logic [7:0] rd_data;
  logic [2:0] irq_flags;
  logic [15:0] blk_count;
  logic [4:0] blk_read_len;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  rx_block_fifo u_rx_block_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_par(rx_par), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .cfg_thresh(cfg_thresh), .cfg_term_en(cfg_term_en),
    .cfg_term_char(cfg_term_char), .cfg_stat_en(cfg_stat_en),
    .cmd_rfrd(cmd_rfrd), .cmd_rmc(cmd_rmc), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .evt_rpf(evt_rpf),
    .evt_tcd(evt_tcd), .evt_ovf(evt_ovf), .irq_flags(irq_flags),
    .irq_ack(irq_ack), .irq(irq), .blk_count(blk_count),
    .blk_read_len(blk_read_len)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  q_read[$];
  logic [7:0]  q_pend[$];
  int          m_unrel;
  logic [15:0] m_acc, m_blk;
  logic        m_rpf, m_tcd, m_ovf;
  logic [2:0]  m_flags;

  function automatic int thr_of(input logic [1:0] s);
    case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 16; default: return 32; endcase
  endfunction
  function automatic logic [4:0] mask_of(input logic [1:0] s);
    case (s) 2'd0: return 5'h01; 2'd1: return 5'h03; 2'd2: return 5'h0F; default: return 5'h1F; endcase
  endfunction

  always @(posedge clk) begin : model
    int used_old, need;
    bit pop, acc_ok, endc;
    if (!rst_n) begin
      q_read.delete(); q_pend.delete();
      m_unrel = 0; m_acc = 0; m_blk = 0;
      m_rpf = 0; m_tcd = 0; m_ovf = 0; m_flags = 0;
    end else begin
      m_flags  = (irq_ack ? 3'b000 : m_flags) | {m_ovf, m_tcd, m_rpf};
      used_old = q_read.size() + q_pend.size() + m_unrel;
      pop      = rd_ready && (q_read.size() > 0);
      if (pop) void'(q_read.pop_front());
      need   = cfg_stat_en ? 2 : 1;
      acc_ok = rx_valid && ((64 - used_old) >= need);
      if (acc_ok) begin
        q_pend.push_back(rx_data);
        if (cfg_stat_en) q_pend.push_back({5'b0, rx_ferr, rx_perr, rx_par});
        m_acc = m_acc + 16'(need);
      end
      endc  = (acc_ok && cfg_term_en && rx_data == cfg_term_char) || cmd_rfrd;
      m_rpf = 0; m_tcd = 0;
      if (endc) begin
        while (q_pend.size() > 0) q_read.push_back(q_pend.pop_front());
        m_blk = m_acc; m_acc = 0; m_tcd = 1;
      end else if (q_pend.size() >= thr_of(cfg_thresh)) begin
        while (q_pend.size() > 0) q_read.push_back(q_pend.pop_front());
        m_rpf = 1;
      end
      m_unrel = (cmd_rmc ? 0 : m_unrel) + (pop ? 1 : 0);
      m_ovf   = rx_valid && !acc_ok;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 rd_valid", rd_valid, q_read.size() > 0);
      if (rd_valid && q_read.size() > 0) chk("R9 rd_data order", rd_data, q_read[0]);
      chk("R3 evt_rpf", evt_rpf, m_rpf);
      chk("R4 evt_tcd", evt_tcd, m_tcd);
      chk("R2 evt_ovf", evt_ovf, m_ovf);
      chk("R11 irq_flags", irq_flags, m_flags);
      chk("R11 irq", irq, |m_flags);
      chk("R6 blk_count", blk_count, m_blk);
      chk("R7 blk_read_len", blk_read_len, m_blk[4:0] & mask_of(cfg_thresh));
      chk("R12 rx_ready", rx_ready, 1'b1);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [7:0] d, input logic p = 0, input logic pe = 0, input logic fe = 0);
    rx_valid = 1; rx_data = d; rx_par = p; rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_valid = 0;
  endtask
  task automatic pulse_rfrd();
    cmd_rfrd = 1; @(negedge clk); cmd_rfrd = 0;
  endtask
  task automatic pulse_rmc();
    cmd_rmc = 1; @(negedge clk); cmd_rmc = 0;
  endtask
  task automatic pulse_ack();
    irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask
  task automatic pop(output logic [7:0] d);
    d = rd_data; rd_ready = 1; @(negedge clk); rd_ready = 0;
  endtask
  task automatic drain();
    while (rd_valid) begin rd_ready = 1; @(negedge clk); end
    rd_ready = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk("R9 watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 flags", irq_flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 blk_count", blk_count, 0);
    chk("R1 events", {evt_rpf, evt_tcd, evt_ovf}, 0);
    chk("R12 ready", rx_ready, 1);

    // R3 threshold of 2
    cfg_thresh = 2'b00;
    send(8'hA1); chk("R3 below threshold", evt_rpf, 0);
    send(8'hA2); chk("R3 pool full", evt_rpf, 1);
    chk("R3 readable", rd_valid, 1);
    @(negedge clk); chk("R11 rpf flag", irq_flags[0], 1);
    pop(b); chk("R9 first byte", b, 8'hA1);
    pop(b); chk("R9 second byte", b, 8'hA2);
    pulse_rmc(); pulse_ack();

    // R5 forced flush, R6 count spans blocks, R7 low bits
    cfg_thresh = 2'b01;
    send(8'h10); send(8'h11); send(8'h12);
    pulse_rfrd();
    chk("R5 tcd on flush", evt_tcd, 1);
    chk("R5 no rpf on flush", evt_rpf, 0);
    chk("R6 count 5", blk_count, 16'd5);
    chk("R7 len low two bits", blk_read_len, 5'd1);
    drain(); pulse_rmc(); pulse_ack();

    // R4 terminator
    cfg_thresh = 2'b10; cfg_term_en = 1; cfg_term_char = 8'h0D;
    send(8'h41); send(8'h0D);
    chk("R4 terminator ends", evt_tcd, 1);
    chk("R6 count 2", blk_count, 16'd2);
    chk("R7 len", blk_read_len, 5'd2);
    drain();
    cfg_term_en = 0;
    send(8'h0D);
    chk("R4 disabled no tcd", evt_tcd, 0);
    chk("R4 disabled not readable", rd_valid, 0);
    pulse_rfrd(); chk("R6 count 1", blk_count, 16'd1);
    drain(); pulse_rmc(); pulse_ack();

    // R8 status bytes
    cfg_thresh = 2'b00; cfg_stat_en = 1;
    send(8'h5A, 1, 0, 1);
    chk("R8 two bytes reach threshold", evt_rpf, 1);
    pop(b); chk("R8 data first", b, 8'h5A);
    pop(b); chk("R8 status second", b, 8'h05);
    pulse_rmc(); cfg_stat_en = 0; pulse_ack();

    // R2 overflow, R10 release
    cfg_thresh = 2'b11;
    for (int i = 0; i < 64; i++) send(8'(i));
    chk("R3 32 threshold", evt_rpf, 1);
    send(8'hEE); chk("R2 overflow", evt_ovf, 1);
    @(negedge clk); chk("R11 ovf flag", irq_flags[2], 1);
    pulse_ack(); chk("R11 ack clears", irq_flags, 0);
    pop(b); chk("R9 oldest", b, 8'h00);
    send(8'h77); chk("R10 no reclaim before release", evt_ovf, 1);
    pulse_rmc();
    send(8'h78); chk("R10 reclaimed after release", evt_ovf, 0);

    // randomised phase compared against the model each cycle
    for (int c = 0; c < 4000; c++) begin
      rx_valid = ($urandom_range(0, 9) < 4);
      rx_data  = ($urandom_range(0, 7) == 0) ? cfg_term_char : 8'($urandom);
      {rx_par, rx_perr, rx_ferr} = 3'($urandom);
      rd_ready = ($urandom_range(0, 9) < 6);
      cmd_rfrd = ($urandom_range(0, 31) == 0);
      cmd_rmc  = ($urandom_range(0, 9) == 0);
      irq_ack  = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 49) == 0) cfg_thresh = 2'($urandom);
      if ($urandom_range(0, 49) == 0) cfg_term_en = ~cfg_term_en;
      if ($urandom_range(0, 99) == 0) cfg_stat_en = ~cfg_stat_en;
      @(negedge clk);
    end
    rx_valid = 0; rd_ready = 0; cmd_rfrd = 0; cmd_rmc = 0; irq_ack = 0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule